// File: doc/BRIEF.md
# Correlation Window Sweep Sequencer

This block steers a synchronous correlator that rebuilds a periodic disturbance by sub-sampling. A divider state counts through every phase of the reference period. The block raises a gate output one cycle after the divider state matches an opening word. It drops the gate one cycle after the state matches a closing word, as a set/reset latch would. When the opening word is later in the period than the closing word, the window wraps across the period boundary.

A run starts on `start_i`. At each window position the block waits for a period boundary and pulses an integrator clear. It then keeps the window open for a programmed number of whole reference periods. After that it raises a sample request to the external converter and waits for the ready answer. It stores the returned sample at the index of the position. Both words then move on by a programmed step, modulo the divider length, and the block treats the next position the same way. After the last position it raises a done flag. A disable input forces the gate low and abandons the run. A start with equal opening and closing words raises an error flag instead of starting a run.

Top module: `corr_window_seq`

## Requirements
- R1: The gate output goes high in the cycle after `div_i` equals the current opening word. It goes low in the cycle after `div_i` equals the current closing word. Otherwise it holds its value.
- R2: When the opening word is greater than the closing word, the window stays open across the period boundary. The gate is high for `div_i` values after the opening word in one period and up to and including the closing word in the next period.
- R3: Each position begins at a period boundary, the cycle in which `div_i` is 0. `integ_clr_o` is high for that one cycle. The position then lasts exactly `integ_i` whole periods; a value of 0 counts as 1.
- R4: Once the last period of a position ends, `smp_req_o` rises in the first cycle of the next period. It stays high, with the gate low, until `smp_ready_i` is seen.
- R5: The sample on `smp_data_i`, taken in the cycle where `smp_req_o` and `smp_ready_i` are both high, is stored at the index of the position (0 for the first). `rd_data_o` returns entry `rd_addr_i` one cycle after the address is applied.
- R6: After each stored sample, the opening word and the closing word both advance by `step_i` modulo `DIV_N`.
- R7: A run covers `npos_i` positions (0 counts as 1, values above 32 are limited to 32). `done_o` rises the cycle after the last sample is accepted and clears on the next accepted start.
- R8: A start while idle with equal opening and closing words sets `err_o` the next cycle and starts no run: no clear pulse, gate low. A later valid start clears `err_o`.
- R9: While `dis_i` is high, the gate is low from the next cycle on, any run is abandoned and a start is ignored. When `dis_i` and `smp_ready_i` arrive in the same cycle, disable wins: no sample is stored and `done_o` stays low.
- R10: After reset, `gate_o`, `integ_clr_o`, `smp_req_o`, `done_o` and `err_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a sweep (one-cycle pulse) |
| dis_i | input | 1 | Force gate low and abandon the sweep |
| div_i | input | DIV_W | Divider state, 0 to DIV_N-1 |
| set_word_i | input | DIV_W | Opening word for position 0 |
| rst_word_i | input | DIV_W | Closing word for position 0 |
| step_i | input | DIV_W | Advance of both words per position |
| npos_i | input | POS_W | Number of positions |
| integ_i | input | INTEG_W | Periods integrated per position |
| smp_ready_i | input | 1 | Converter has a sample on smp_data_i |
| smp_data_i | input | SAMP_W | Digitized correlator output |
| rd_addr_i | input | AW | Sample buffer read index |
| gate_o | output | 1 | Correlation window |
| integ_clr_o | output | 1 | Integrator clear at start of a position |
| smp_req_o | output | 1 | Request a sample |
| done_o | output | 1 | Sweep complete |
| err_o | output | 1 | Start refused: equal words |
| rd_data_o | output | SAMP_W | Sample buffer read data |

## Verification
Disable and the converter's ready answer can land in the same cycle, and each one on its own would change the buffer and the done flag. The bench runs a one-position sweep, waits for the sample request, and then drives `dis_i` and `smp_ready_i` high together with a marker value on the data bus. The result is judged at the ports. The request must fall and `done_o` must stay low. Buffer entry 0, read back through the read port, must still hold the sample from the previous sweep and not the marker.

// File: rtl/corr_seq_pkg.sv
package corr_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ALIGN = 2'd1,
    ST_INTEG = 2'd2,
    ST_REQ   = 2'd3
  } seq_st_t;
endpackage

// File: rtl/cws_gate.sv
module cws_gate #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] open_w,
  input  logic [DIV_W-1:0] close_w,
  output logic             gate_o
);
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      gate_o <= 1'b0;
    end else if (div == open_w) begin
      gate_o <= 1'b1;
    end else if (div == close_w) begin
      gate_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cws_period_cnt.sv
module cws_period_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
  assign last_o  = tick && (cnt_inc >= {1'b0, limit});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_inc[W-1:0];
    end
  end
endmodule

// File: rtl/cws_mod_step.sv
module cws_mod_step #(
  parameter int DIV_N = 50,
  parameter int DIV_W = 6
) (
  input  logic [DIV_W-1:0] cur,
  input  logic [DIV_W-1:0] step,
  output logic [DIV_W-1:0] nxt
);
  localparam logic [DIV_W:0] N_EXT = (DIV_W+1)'(DIV_N);
  logic [DIV_W:0] sum;
  logic [DIV_W:0] wrapped;

  assign sum     = {1'b0, cur} + {1'b0, step};
  assign wrapped = sum - N_EXT;
  assign nxt     = (sum >= N_EXT) ? wrapped[DIV_W-1:0] : sum[DIV_W-1:0];
endmodule

// File: rtl/cws_sample_buf.sv
module cws_sample_buf #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/corr_window_seq.sv
module corr_window_seq #(
  parameter int DIV_N   = 50,
  parameter int MAX_POS = 32,
  parameter int SAMP_W  = 12,
  parameter int INTEG_W = 10,
  localparam int DIV_W  = $clog2(DIV_N),
  localparam int AW     = $clog2(MAX_POS),
  localparam int POS_W  = $clog2(MAX_POS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               dis_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [DIV_W-1:0]   set_word_i,
  input  logic [DIV_W-1:0]   rst_word_i,
  input  logic [DIV_W-1:0]   step_i,
  input  logic [POS_W-1:0]   npos_i,
  input  logic [INTEG_W-1:0] integ_i,
  input  logic               smp_ready_i,
  input  logic [SAMP_W-1:0]  smp_data_i,
  input  logic [AW-1:0]      rd_addr_i,
  output logic               gate_o,
  output logic               integ_clr_o,
  output logic               smp_req_o,
  output logic               done_o,
  output logic               err_o,
  output logic [SAMP_W-1:0]  rd_data_o
);
  import corr_seq_pkg::*;

  localparam logic [DIV_W-1:0] LAST_ST = DIV_W'(DIV_N - 1);
  localparam logic [AW-1:0]    LAST_IX = AW'(MAX_POS - 1);

  seq_st_t            st_q;
  logic [DIV_W-1:0]   set_q, rst_q, step_q;
  logic [DIV_W-1:0]   set_nxt, rst_nxt;
  logic [POS_W-1:0]   npos_q;
  logic [INTEG_W-1:0] integ_q;
  logic [AW-1:0]      pos_q;
  logic               period_end, int_last, gate_en, pos_last, wr_en, busy_w;
  logic [POS_W:0]     pos_inc;

  assign period_end = (div_i == LAST_ST);
  assign busy_w     = (st_q != ST_IDLE);
  assign gate_en    = (st_q == ST_INTEG) && !dis_i && !int_last;
  assign pos_inc    = (POS_W+1)'(pos_q) + (POS_W+1)'(1);
  assign pos_last   = (pos_inc >= {1'b0, npos_q}) || (pos_q == LAST_IX);
  assign wr_en      = (st_q == ST_REQ) && smp_ready_i && !dis_i;

  cws_gate #(.DIV_W(DIV_W)) gate_i (
    .clk(clk), .rst(rst), .en(gate_en), .div(div_i),
    .open_w(set_q), .close_w(rst_q), .gate_o(gate_o)
  );

  cws_period_cnt #(.W(INTEG_W)) cnt_i (
    .clk(clk), .rst(rst), .clr(st_q != ST_INTEG),
    .tick(period_end && (st_q == ST_INTEG)), .limit(integ_q), .last_o(int_last)
  );

  cws_mod_step #(.DIV_N(DIV_N), .DIV_W(DIV_W)) step_set_i (
    .cur(set_q), .step(step_q), .nxt(set_nxt)
  );

  cws_mod_step #(.DIV_N(DIV_N), .DIV_W(DIV_W)) step_rst_i (
    .cur(rst_q), .step(step_q), .nxt(rst_nxt)
  );

  cws_sample_buf #(.DEPTH(MAX_POS), .AW(AW), .DW(SAMP_W)) buf_i (
    .clk(clk), .we(wr_en), .waddr(pos_q), .wdata(smp_data_i),
    .raddr(rd_addr_i), .rdata(rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      set_q       <= '0;
      rst_q       <= '0;
      step_q      <= '0;
      npos_q      <= '0;
      integ_q     <= '0;
      pos_q       <= '0;
      integ_clr_o <= 1'b0;
      smp_req_o   <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      integ_clr_o <= 1'b0;
      if (dis_i) begin
        st_q      <= ST_IDLE;
        smp_req_o <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (start_i) begin
              if (set_word_i == rst_word_i) begin
                err_o <= 1'b1;
              end else begin
                err_o   <= 1'b0;
                done_o  <= 1'b0;
                set_q   <= set_word_i;
                rst_q   <= rst_word_i;
                step_q  <= step_i;
                npos_q  <= npos_i;
                integ_q <= integ_i;
                pos_q   <= '0;
                st_q    <= ST_ALIGN;
              end
            end
          end
          ST_ALIGN: begin
            if (period_end) begin
              integ_clr_o <= 1'b1;
              st_q        <= ST_INTEG;
            end
          end
          ST_INTEG: begin
            if (int_last) begin
              smp_req_o <= 1'b1;
              st_q      <= ST_REQ;
            end
          end
          default: begin
            if (smp_ready_i) begin
              smp_req_o <= 1'b0;
              if (pos_last) begin
                done_o <= 1'b1;
                st_q   <= ST_IDLE;
              end else begin
                pos_q <= pos_q + AW'(1);
                set_q <= set_nxt;
                rst_q <= rst_nxt;
                st_q  <= ST_ALIGN;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/corr_window_seq_chk.sv
module corr_window_seq_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             dis_i,
  input logic [DIV_W-1:0] div_i,
  input logic [DIV_W-1:0] set_word_i,
  input logic [DIV_W-1:0] rst_word_i,
  input logic             smp_ready_i,
  input logic             gate_o,
  input logic             integ_clr_o,
  input logic             smp_req_o,
  input logic             done_o,
  input logic             err_o,
  input logic             busy,
  input logic [DIV_W-1:0] open_word
);
  // R9
  gate_off_dis_chk: assert property (@(posedge clk) disable iff (rst)
    dis_i |=> !gate_o);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_req_o && !smp_ready_i && !dis_i) |=> smp_req_o);

  // R3
  clr_req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(integ_clr_o && smp_req_o));

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && !dis_i && (set_word_i == rst_word_i)) |=> err_o);

  // R1
  gate_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> ($past(div_i) == $past(open_word)));

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(smp_ready_i && smp_req_o));
endmodule

bind corr_window_seq corr_window_seq_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .dis_i(dis_i), .div_i(div_i),
  .set_word_i(set_word_i), .rst_word_i(rst_word_i), .smp_ready_i(smp_ready_i),
  .gate_o(gate_o), .integ_clr_o(integ_clr_o), .smp_req_o(smp_req_o),
  .done_o(done_o), .err_o(err_o), .busy(busy_w), .open_word(set_q)
);

// File: tb/corr_window_seq_tb_top.sv
module corr_window_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 10;
  localparam int DW    = 4;
  localparam int NROWS = 6;
  // columns: open word, close word, step, positions, periods per position
  localparam int VEC [NROWS][5] = '{
    '{2, 5, 1, 3, 2},
    '{7, 3, 2, 4, 1},
    '{0, 9, 3, 5, 3},
    '{9, 0, 1, 2, 2},
    '{4, 8, 7, 3, 1},
    '{1, 6, 1, 32, 1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, dis = 1'b0, ready = 1'b0;
  logic [DW-1:0] div = '0, setw = '0, rstw = '0, step = '0;
  logic [5:0]  npos = '0;
  logic [9:0]  integ = '0;
  logic [11:0] sdata = '0;
  logic [4:0]  raddr = '0;
  logic gate, iclr, req, done, err;
  logic [11:0] rdata;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) div <= (div == DW'(N-1)) ? '0 : div + 1'b1;

  corr_window_seq #(.DIV_N(N), .MAX_POS(32), .SAMP_W(12), .INTEG_W(10)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .dis_i(dis), .div_i(div),
    .set_word_i(setw), .rst_word_i(rstw), .step_i(step), .npos_i(npos),
    .integ_i(integ), .smp_ready_i(ready), .smp_data_i(sdata), .rd_addr_i(raddr),
    .gate_o(gate), .integ_clr_o(iclr), .smp_req_o(req), .done_o(done),
    .err_o(err), .rd_data_o(rdata)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_gate(int s, int r, int ig);
    if (s < r) return ig * (r - s);
    return ig * (N - 1 - s) + (ig - 1) * (r + 1);
  endfunction

  function automatic int smp_val(int row, int p);
    return 100 + row * 40 + p;
  endfunction

  task automatic kick(int s, int r, int st, int np, int ig);
    @(negedge clk);
    setw = DW'(s); rstw = DW'(r); step = DW'(st);
    npos = 6'(np); integ = 10'(ig); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_row(int row);
    int s0 = VEC[row][0], r0 = VEC[row][1], st = VEC[row][2];
    int np = VEC[row][3], ig = VEC[row][4];
    kick(s0, r0, st, np, ig);
    for (int p = 0; p < np; p++) begin
      int s = (s0 + p * st) % N;
      int r = (r0 + p * st) % N;
      int gcnt = 0, clrs = 0, len = 0;
      while (!req) begin
        if (iclr) clrs++;
        if (clrs > 0) len++;
        if (gate) gcnt++;
        @(negedge clk);
      end
      // R1 R2 R6: gate high count for advanced words
      chk($sformatf("R1/R2/R6 row%0d pos%0d gate cycles", row, p), gcnt, exp_gate(s, r, ig));
      chk($sformatf("R3 row%0d pos%0d clear pulses", row, p), clrs, 1);
      chk($sformatf("R3 row%0d pos%0d position length", row, p), len, ig * N);
      chk($sformatf("R4 row%0d pos%0d gate low at request", row, p), int'(gate), 0);
      ready = 1'b1; sdata = 12'(smp_val(row, p));
      @(negedge clk);
      ready = 1'b0;
      chk($sformatf("R4 row%0d pos%0d request dropped", row, p), int'(req), 0);
    end
    chk($sformatf("R7 row%0d done", row), int'(done), 1);
    for (int p = 0; p < np; p++) begin
      raddr = 5'(p);
      @(negedge clk);
      chk($sformatf("R5 row%0d entry%0d", row, p), int'(rdata), smp_val(row, p));
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=finish", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 gate", int'(gate), 0);
    chk("R10 clear", int'(iclr), 0);
    chk("R10 request", int'(req), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);

    for (int row = 0; row < NROWS; row++) run_row(row);

    // R7 start clears done; R8 equal words refused
    kick(4, 4, 1, 2, 1);
    chk("R8 err set", int'(err), 1);
    chk("R7 done kept on refused start", int'(done), 1);
    begin
      int act = 0;
      for (int i = 0; i < 2 * N; i++) begin
        @(negedge clk);
        if (iclr || gate) act++;
      end
      chk("R8 no run after refused start", act, 0);
    end

    // R9 disable mid-run
    kick(2, 5, 1, 2, 3);
    chk("R8 err cleared by valid start", int'(err), 0);
    chk("R7 done cleared by start", int'(done), 0);
    repeat (15) @(negedge clk);
    dis = 1'b1;
    @(negedge clk);
    chk("R9 gate low under disable", int'(gate), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dis = 1'b0;
    begin
      int act = 0;
      for (int i = 0; i < 3 * N; i++) begin
        @(negedge clk);
        if (iclr || req || gate) act++;
      end
      chk("R9 sequence stopped, start ignored", act, 0);
    end

    // R9 disable together with ready
    kick(2, 5, 1, 1, 1);
    while (!req) @(negedge clk);
    ready = 1'b1; dis = 1'b1; sdata = 12'hABC;
    @(negedge clk);
    ready = 1'b0; dis = 1'b0;
    chk("R9 request dropped on disable", int'(req), 0);
    chk("R9 no done when disable meets ready", int'(done), 0);
    raddr = 5'd0;
    @(negedge clk);
    chk("R9 entry0 not written", int'(rdata), smp_val(5, 0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule